// File: doc/BRIEF.md
# Push-button counter and FIFO demonstrator

The block is a small top-level design for a board with four push-buttons and four LEDs. One button is a reset request. It enters the clock domain through a reset synchronizer that asserts at once and releases in step with the clock. The other three buttons pass through two-flop synchronizers and a debouncer. Each debounced level then feeds an edge detector, which gives one single-cycle pulse for each physical press.

The three pulses act on a 4-bit wrapping counter and a synchronous FIFO. One pulse increments the counter. One pushes the counter value into the FIFO. One pops the oldest entry. The LEDs show the entry at the head of the FIFO.

The debouncer does not give each button a full-width settle counter. A single prescaler produces a one-cycle tick every 2^PRESCALE_BITS clocks. Each button then needs only a small counter of ticks. With the defaults (a 50 MHz clock, 2^16 clocks per tick, 19 ticks) the settle time is about 25 ms.

Top module: `button_fifo_demo`

## Requirements
- R1: While `btn_i[3]` is high the internal reset is active. The internal reset is released two rising clock edges after the button goes low. Reset clears the counter, the FIFO and the debounced states, so `led_o` reads 0.
- R2: Each of `btn_i[2:0]` is taken through a two-flop synchronizer. Its debounced level changes only after the synchronized input has been stable for SETTLE_TICKS prescaler ticks. Any change of the input restarts that count, so a glitch shorter than the settle time has no effect.
- R3: A single prescaler is shared by all three buttons. It issues a one-cycle tick every 2^PRESCALE_BITS clocks, never on two consecutive cycles. A press held for longer than (SETTLE_TICKS+1)·2^PRESCALE_BITS plus four clocks is always accepted.
- R4: A press yields exactly one single-cycle pulse, even when it bounces on the way down or on the way up.
- R5: A press of `btn_i[2]` (increment) adds one to the 4-bit counter, wrapping from 15 to 0.
- R6: A press of `btn_i[0]` (store) pushes the current counter value into the FIFO.
- R7: A press of `btn_i[1]` (show next) removes the head entry. `led_o` equals the head entry when the FIFO holds data and equals 0 when it is empty.
- R8: A store while the FIFO holds DEPTH entries is ignored, and the stored contents are unchanged.
- R9: A show-next while the FIFO is empty is ignored, and a later store is still read back correctly.
- R10: Entries leave the FIFO in the order they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| btn_i | input | 4 | Raw buttons, high when pressed: [0] store, [1] show next, [2] increment, [3] reset |
| led_o | output | 4 | Head entry of the FIFO, or 0 when the FIFO is empty |

## Verification
The assertions check the following on every cycle:
- the prescaler tick is never high on two consecutive cycles;
- each press pulse is one cycle wide;
- the counter steps by exactly one on an increment;
- the FIFO fill level does not change on a store into a full FIFO or a show-next from an empty one;
- the LEDs are dark while the FIFO is empty.

Some behaviour is visible only over many cycles, and only the bench scenarios can show it:
- bouncing presses still give one action;
- short glitches are rejected;
- a minimal held press is accepted;
- the FIFO returns entries in store order;
- the reset button clears everything.

// File: rtl/button_fifo_demo_pkg.sv
// Shared constants for the button/FIFO demonstrator: button roles and counts.
// Assumes the board provides exactly four buttons, high when pressed.
package button_fifo_demo_pkg;
    localparam int NUM_BTN   = 4;
    localparam int NUM_ACT   = 3;   // buttons that are debounced into actions
    localparam int BTN_STORE = 0;
    localparam int BTN_SHOW  = 1;
    localparam int BTN_INC   = 2;
    localparam int BTN_RST   = 3;
    localparam int CNT_W     = 4;
endpackage

// File: rtl/bfd_reset_sync.sv
// Reset synchronizer: turns a raw, active-high reset request into an
// active-low reset that asserts asynchronously and releases after STAGES
// clock edges. Assumes the request may arrive at any time.
module bfd_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic req_i,
    output logic rst_n_o
);
    logic         req_n;
    logic [STAGES-1:0] chain_q;

    assign req_n = ~req_i;

    // Shift ones in after release; clear the chain at once on a request.
    always_ff @(posedge clk or negedge req_n) begin
        if (!req_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/bfd_debouncer.sv
// Multi-channel debouncer with one shared prescaler. Each channel is
// synchronized by two flops, then its debounced level follows the input only
// after the input has been stable for SETTLE_TICKS prescaler ticks.
// Assumes a synchronous active-low reset from the reset synchronizer.
module bfd_debouncer #(
    parameter int N_CH          = 3,
    parameter int PRESCALE_BITS = 16,
    parameter int SETTLE_TICKS  = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] raw_i,
    output logic [N_CH-1:0] level_o,
    output logic            tick_o
);
    localparam int TCNT_W = $clog2(SETTLE_TICKS + 1);

    logic [PRESCALE_BITS-1:0] presc_q;

    // Free-running shared prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + 1'b1;
    end

    assign tick_o = &presc_q;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic              s1_q, s2_q, prev_q, lvl_q;
        logic [TCNT_W-1:0] tcnt_q;

        // Two-flop synchronizer and one-cycle history of the input.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= raw_i[g];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        // Count stable ticks; adopt the new level after SETTLE_TICKS of them.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tcnt_q <= '0;
                lvl_q  <= 1'b0;
            end else if (s2_q != prev_q || s2_q == lvl_q) begin
                tcnt_q <= '0;
            end else if (tick_o) begin
                if (tcnt_q == TCNT_W'(SETTLE_TICKS - 1)) begin
                    lvl_q  <= s2_q;
                    tcnt_q <= '0;
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
            end
        end

        assign level_o[g] = lvl_q;
    end
endmodule

// File: rtl/bfd_rise_detect.sv
// Rising-edge detector: one-cycle pulse per low-to-high change of each bit.
// Assumes inputs are already synchronous and debounced.
module bfd_rise_detect #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] last_q;

    // Remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= level_i;
    end

    assign rise_o = level_i & ~last_q;
endmodule

// File: rtl/bfd_fifo.sv
// Synchronous FIFO on an inferred RAM with a valid/ready style interface.
// The head entry is visible on rd_data_o while rd_valid_o is high. Pushes when
// full and pops when empty are dropped. Assumes a synchronous active-low reset.
module bfd_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 4096
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WIDTH-1:0]             wr_data_i,
    input  logic                         wr_valid_i,
    output logic                         wr_ready_o,
    output logic [WIDTH-1:0]             rd_data_o,
    output logic                         rd_valid_o,
    input  logic                         rd_ready_i,
    output logic [$clog2(DEPTH+1)-1:0]   level_o
);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic [WIDTH-1:0]  mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [LVL_W-1:0]  level_q;
    logic              push, pop;

    assign wr_ready_o = (level_q != LVL_W'(DEPTH));
    assign rd_valid_o = (level_q != '0);
    assign push       = wr_valid_i & wr_ready_o;
    assign pop        = rd_ready_i & rd_valid_o;

    // Storage array, written only on accepted pushes.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr_q] <= wr_data_i;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == ADDR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == ADDR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            case ({push, pop})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    assign rd_data_o = mem[rd_ptr_q];
    assign level_o   = level_q;
endmodule

// File: rtl/button_fifo_demo.sv
// Top of the push-button demonstrator. Button 3 resets the design. Buttons
// 0..2 are debounced and edge-detected into store, show-next and increment
// actions on a 4-bit counter and a FIFO, whose head drives the LEDs.
// Assumes buttons are high when pressed and the design is reset once first.
module button_fifo_demo
    import button_fifo_demo_pkg::*;
#(
    parameter int PRESCALE_BITS = 16,
    parameter int SETTLE_TICKS  = 19,
    parameter int DEPTH         = 4096
) (
    input  logic             clk,
    input  logic [NUM_BTN-1:0] btn_i,
    output logic [CNT_W-1:0]   led_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic               rst_n;
    logic               tick;
    logic [NUM_ACT-1:0] level;
    logic [NUM_ACT-1:0] rise;
    logic [CNT_W-1:0]   count_q;
    logic [CNT_W-1:0]   head;
    logic               head_valid;
    logic               store_ready;
    logic [LVL_W-1:0]   fifo_level;

    bfd_reset_sync #(.STAGES(2)) u_rst (
        .clk     (clk),
        .req_i   (btn_i[BTN_RST]),
        .rst_n_o (rst_n)
    );

    bfd_debouncer #(
        .N_CH          (NUM_ACT),
        .PRESCALE_BITS (PRESCALE_BITS),
        .SETTLE_TICKS  (SETTLE_TICKS)
    ) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (btn_i[NUM_ACT-1:0]),
        .level_o (level),
        .tick_o  (tick)
    );

    bfd_rise_detect #(.N(NUM_ACT)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level),
        .rise_o  (rise)
    );

    // Wrapping press counter.
    always_ff @(posedge clk) begin
        if (!rst_n)             count_q <= '0;
        else if (rise[BTN_INC]) count_q <= count_q + 1'b1;
    end

    bfd_fifo #(.WIDTH(CNT_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_i  (count_q),
        .wr_valid_i (rise[BTN_STORE]),
        .wr_ready_o (store_ready),
        .rd_data_o  (head),
        .rd_valid_o (head_valid),
        .rd_ready_i (rise[BTN_SHOW]),
        .level_o    (fifo_level)
    );

    assign led_o = head_valid ? head : '0;
endmodule

// File: rtl/button_fifo_demo_chk.sv
// Checker for button_fifo_demo, attached by bind. Observes internal reset,
// prescaler tick, press pulses, counter and FIFO level.
module button_fifo_demo_chk #(
    parameter int DEPTH = 4096,
    parameter int LVL_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [2:0]       rise,
    input logic [3:0]       count_q,
    input logic [LVL_W-1:0] fifo_level,
    input logic [3:0]       led_o
);
    logic full, empty;
    assign full  = (fifo_level == LVL_W'(DEPTH));
    assign empty = (fifo_level == '0);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R3
    AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rise[0] |=> !rise[0]); // R4
    AST_SHOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rise[1] |=> !rise[1]); // R4
    AST_INC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rise[2] |=> !rise[2]); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) rise[2] |=> count_q == $past(count_q) + 4'd1); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (full && rise[0] && !rise[1]) |=> fifo_level == $past(fifo_level)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (empty && rise[1] && !rise[0]) |=> fifo_level == '0); // R9
    AST_DARK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) empty |-> led_o == 4'd0); // R7
endmodule

bind button_fifo_demo button_fifo_demo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .rise       (rise),
    .count_q    (count_q),
    .fifo_level (fifo_level),
    .led_o      (led_o)
);

// File: tb/test_button_fifo_demo.sv
// Bench for button_fifo_demo: directed corner cases plus seeded random presses,
// compared against a reference model of counter and FIFO.
module test_button_fifo_demo;
    localparam int PB    = 2;
    localparam int ST    = 3;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic [3:0] btn = 4'b0000;
    logic [3:0] led;

    int tests = 0;
    int fails = 0;
    logic [3:0] model_q[$];
    logic [3:0] model_cnt = 4'd0;

    always #4 clk = ~clk;

    button_fifo_demo #(.PRESCALE_BITS(PB), .SETTLE_TICKS(ST), .DEPTH(DEPTH)) i_button_fifo_demo (
        .clk   (clk),
        .btn_i (btn),
        .led_o (led)
    );

    function automatic logic [3:0] exp_led();
        return (model_q.size() > 0) ? model_q[0] : 4'd0;
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        @(negedge clk);
        tests++;
        if (led !== exp) begin
            fails++;
            $display("FAIL %s: led=%0d expected=%0d", req, led, exp);
        end
    endtask

    task automatic model_press(input int idx);
        case (idx)
            0: if (model_q.size() < DEPTH) model_q.push_back(model_cnt);
            1: if (model_q.size() > 0) void'(model_q.pop_front());
            2: model_cnt = model_cnt + 4'd1;
            default: ;
        endcase
    endtask

    task automatic press(input int idx, input bit bounce, input int hold);
        if (bounce) for (int k = 0; k < 3; k++) begin
            btn[idx] = 1'b1; repeat (2) @(posedge clk);
            btn[idx] = 1'b0; repeat (2) @(posedge clk);
        end
        btn[idx] = 1'b1;
        repeat (hold) @(posedge clk);
        if (bounce) for (int k = 0; k < 3; k++) begin
            btn[idx] = 1'b0; repeat (2) @(posedge clk);
            btn[idx] = 1'b1; repeat (2) @(posedge clk);
        end
        btn[idx] = 1'b0;
        repeat (40) @(posedge clk);
        model_press(idx);
    endtask

    task automatic do_reset();
        btn[3] = 1'b1;
        repeat (3) @(posedge clk);
        check("R1 held", 4'd0);
        btn[3] = 1'b0;
        repeat (5) @(posedge clk);
        model_q.delete();
        model_cnt = 4'd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: led=%0d expected=%0d", led, exp_led());
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        check("R1 after reset", 4'd0);

        // R5 R6: increment then store, clean presses
        press(2, 0, 40); press(2, 0, 40); press(0, 0, 40);
        check("R6 store", exp_led());
        // R4: bouncing increment and store count once
        press(2, 1, 40); press(0, 1, 40);
        check("R4 bounce", exp_led());
        // R2: short glitch on increment ignored, visible via next store
        btn[2] = 1'b1; repeat (5) @(posedge clk); btn[2] = 1'b0;
        repeat (40) @(posedge clk);
        press(0, 0, 40);
        check("R2 glitch", exp_led());
        // R3: minimal held press accepted
        press(2, 0, (ST + 1) * (1 << PB) + 6); press(0, 0, 40);
        check("R3 min hold", exp_led());
        // R7 R10: drain in order
        for (int i = 0; i < 3; i++) begin
            press(1, 0, 40);
            check("R10 order", exp_led());
        end
        press(1, 0, 40);
        check("R7 empty dark", exp_led());
        // R9: pop on empty, then store still works
        press(1, 1, 40);
        check("R9 empty pop", exp_led());
        press(0, 0, 40);
        check("R9 store after", exp_led());
        press(1, 0, 40);

        // R8: overfill with distinct values, then drain
        do_reset();
        for (int i = 0; i < DEPTH + 2; i++) begin
            press(2, 0, 30); press(0, 0, 30);
        end
        check("R8 full head", exp_led());
        for (int i = 0; i < DEPTH; i++) begin
            press(1, 0, 30);
            check("R8 drain", exp_led());
        end

        // R5: wrap of the counter past 15
        for (int i = 0; i < 17; i++) press(2, 0, 30);
        press(0, 0, 30);
        check("R5 wrap", exp_led());

        // Random mix of store, show-next and increment
        for (int i = 0; i < 60; i++) begin
            int op;
            op = int'($urandom % 3);
            press(op, bit'($urandom % 2), 30);
            check("R7 random", exp_led());
        end

        // R1: reset mid-run clears stored data
        press(0, 0, 30);
        do_reset();
        check("R1 clear", 4'd0);
        press(0, 0, 30);
        check("R1 count cleared", exp_led());

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule